// File: doc/BRIEF.md
# Processor Exception Entry Unit

This block produces the architectural state a core must commit when it takes an exception or a reset. The core presents a single-cycle request with a fault type, the faulting PC and the PC that would have followed, and the present Status, Cause and shadow-set control words. One clock later the unit presents the new Status, Cause, EPC and shadow-set control words, an EPC write enable, and the address of the handler the fetch stage must jump to.

For ordinary faults the unit marks the core as being at exception level. It backs EPC up to the branch when the faulting instruction sits in a branch delay slot. It records the fault's code in Cause, and it rotates the shadow register set fields only when the core was neither at exception level nor in boot-vector mode. A reset request goes to the fixed reset address and makes the floating-point coprocessor usable. It leaves EPC, Cause and the exception-level bit alone. Choosing between faults that arrive together is left to the requester.

Top module: `exc_entry_unit`

## Requirements
- R1: A request with `req_valid` high while `commit_valid` is low makes `commit_valid` high for exactly one cycle on the next clock edge, with all outputs valid in that cycle. A request made while `commit_valid` is high is ignored, so `commit_valid` is low in the following cycle and the outputs do not change.
- R2: For every non-reset fault, `status_out` equals `status_in` with bit 1 (exception level) set to 1, including when that bit was already 1. `epc_we` is 1.
- R3: For a non-reset fault with status bit 1 and bit 22 (boot-vector mode) both 0, `srsctl_out` takes bits [3:0] (current set) into [9:6] (previous set) and bits [15:12] (exception set) into [3:0]. All other bits are unchanged. If either status bit is 1, `srsctl_out` equals `srsctl_in`.
- R4: The faulting instruction is in a delay slot when `next_pc` differs from `cur_pc + 4`. `epc_out` is then `cur_pc - 4`; otherwise it is `cur_pc`.
- R5: For a non-reset fault, `cause_out` equals `cause_in` with bit 31 set to the delay-slot flag, bits [29:28] cleared and bits [6:2] set to the fault's exception code. All other bits are unchanged.
- R6: Fault type input codes are: 0 interrupt, 1 TLB modified, 2 TLB refill, 3 TLB invalid, 4 address error, 5 syscall, 6 breakpoint, 7 reserved instruction, 8 coprocessor unusable, 9 overflow, 10 trap, 11 machine check, 12 thread, 13 DSP disabled, 14 reset, 15 soft reset, 16 NMI. The exception codes written are: interrupt 0, TLB modified 1, syscall 8, breakpoint 9, reserved instruction 10, coprocessor unusable 11, overflow 12, trap 13, machine check 24. Every other type writes 0.
- R7: For a non-reset fault, `redirect_pc` is a base plus an offset. The base is 0x8000_0000 when status bit 22 is 0 and 0xBFC0_0200 when it is 1. The offset is 0x000 for interrupt, soft reset and NMI, and 0x180 for every other type.
- R8: A reset fault gives `redirect_pc` = 0xBFC0_0000, `epc_we` = 0, `status_out` = `status_in` with bit 29 set, and `cause_out` and `srsctl_out` equal to their inputs.
- R9: After reset is released, `commit_valid` is 0 until a request is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle exception request |
| req_fault | input | 5 | Fault type code |
| cur_pc | input | 32 | PC of the faulting instruction |
| next_pc | input | 32 | PC that would have followed |
| status_in | input | 32 | Present Status word |
| cause_in | input | 32 | Present Cause word |
| srsctl_in | input | 32 | Present shadow-set control word |
| commit_valid | output | 1 | Outputs below are to be committed this cycle |
| status_out | output | 32 | New Status word |
| cause_out | output | 32 | New Cause word |
| srsctl_out | output | 32 | New shadow-set control word |
| epc_out | output | 32 | New EPC value |
| epc_we | output | 1 | EPC and exception-level update applies |
| redirect_pc | output | 32 | Handler or reset address |

## Verification
The bench targets the delay-slot case, where a design that skipped the correction would leave EPC on the slot instruction and BD clear. It covers entry with the exception level already set or boot mode on, where a design that rotated the shadow fields anyway would corrupt the previous set. Low-vector faults and the boot base are checked because a wrong offset or base sends fetch to the wrong handler. A reset request is checked to confirm it leaves EPC, Cause and the exception level alone, and a back-to-back request is checked to show that a second commit never appears.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
   localparam int FAULT_W = 5;
   localparam int CODE_W  = 5;

   typedef enum logic [FAULT_W-1:0] {
      FT_INT          = 5'd0,
      FT_TLB_MOD      = 5'd1,
      FT_TLB_REFILL   = 5'd2,
      FT_TLB_INVALID  = 5'd3,
      FT_ADDR_ERR     = 5'd4,
      FT_SYSCALL      = 5'd5,
      FT_BREAK        = 5'd6,
      FT_RSVD_INSN    = 5'd7,
      FT_COP_UNUSABLE = 5'd8,
      FT_OVERFLOW     = 5'd9,
      FT_TRAP         = 5'd10,
      FT_MCHECK       = 5'd11,
      FT_THREAD       = 5'd12,
      FT_DSP_OFF      = 5'd13,
      FT_RESET        = 5'd14,
      FT_SOFT_RESET   = 5'd15,
      FT_NMI          = 5'd16
   } fault_e;

   // status bit positions
   localparam int ST_EXL = 1;
   localparam int ST_BEV = 22;
   localparam int ST_CU1 = 29;
   // cause bit positions
   localparam int CA_BD     = 31;
   localparam int CA_CE_LO  = 28;
   localparam int CA_EXC_LO = 2;
   // shadow-set control field positions
   localparam int SRS_CUR_LO  = 0;
   localparam int SRS_PREV_LO = 6;
   localparam int SRS_EXC_LO  = 12;
endpackage

// File: rtl/exc_code_map.sv
module exc_code_map
   import exc_entry_pkg::*;
(
   input  logic [FAULT_W-1:0] fault_i,
   output logic [CODE_W-1:0]  code_o,
   output logic               low_off_o,
   output logic               is_reset_o
);
   always_comb begin
      code_o     = '0;
      low_off_o  = 1'b0;
      is_reset_o = 1'b0;
      case (fault_i)
         FT_INT:          begin code_o = 5'd0; low_off_o = 1'b1; end
         FT_TLB_MOD:      code_o = 5'd1;
         FT_SYSCALL:      code_o = 5'd8;
         FT_BREAK:        code_o = 5'd9;
         FT_RSVD_INSN:    code_o = 5'd10;
         FT_COP_UNUSABLE: code_o = 5'd11;
         FT_OVERFLOW:     code_o = 5'd12;
         FT_TRAP:         code_o = 5'd13;
         FT_MCHECK:       code_o = 5'd24;
         FT_RESET:        begin low_off_o = 1'b1; is_reset_o = 1'b1; end
         FT_SOFT_RESET:   low_off_o = 1'b1;
         FT_NMI:          low_off_o = 1'b1;
         default:         code_o = '0;
      endcase
   end
endmodule

// File: rtl/exc_state_calc.sv
module exc_state_calc
   import exc_entry_pkg::*;
#(
   parameter int          XLEN          = 32,
   parameter int          INSN_BYTES    = 4,
   parameter int          SRS_W         = 4,
   parameter bit          HAS_DELAY_SLOT = 1'b1,
   parameter logic [31:0] VEC_NORMAL    = 32'h8000_0000,
   parameter logic [31:0] VEC_BOOT      = 32'hBFC0_0200,
   parameter logic [31:0] RESET_VEC     = 32'hBFC0_0000,
   parameter logic [31:0] GEN_OFFSET    = 32'h0000_0180
) (
   input  logic [XLEN-1:0]   pc_i,
   input  logic [XLEN-1:0]   npc_i,
   input  logic [XLEN-1:0]   status_i,
   input  logic [XLEN-1:0]   cause_i,
   input  logic [XLEN-1:0]   srs_i,
   input  logic [CODE_W-1:0] code_i,
   input  logic              low_off_i,
   input  logic              is_reset_i,
   output logic [XLEN-1:0]   status_o,
   output logic [XLEN-1:0]   cause_o,
   output logic [XLEN-1:0]   srs_o,
   output logic [XLEN-1:0]   epc_o,
   output logic [XLEN-1:0]   target_o,
   output logic              epc_we_o
);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);
   localparam logic [XLEN-1:0] OFF  = XLEN'(GEN_OFFSET);

   logic in_slot;
   logic srs_rotate;
   logic [XLEN-1:0] base;

   generate
      if (HAS_DELAY_SLOT) begin : g_slot
         assign in_slot = (npc_i != pc_i + STEP);
      end else begin : g_noslot
         assign in_slot = 1'b0;
      end
   endgenerate

   assign srs_rotate = !status_i[ST_EXL] && !status_i[ST_BEV];
   assign base       = status_i[ST_BEV] ? XLEN'(VEC_BOOT) : XLEN'(VEC_NORMAL);

   always_comb begin
      status_o = status_i;
      cause_o  = cause_i;
      srs_o    = srs_i;
      epc_o    = in_slot ? (pc_i - STEP) : pc_i;
      target_o = base + (low_off_i ? '0 : OFF);
      epc_we_o = 1'b1;
      if (is_reset_i) begin
         status_o[ST_CU1] = 1'b1;
         target_o         = XLEN'(RESET_VEC);
         epc_we_o         = 1'b0;
      end else begin
         status_o[ST_EXL]                     = 1'b1;
         cause_o[CA_BD]                       = in_slot;
         cause_o[CA_CE_LO +: 2]               = 2'b00;
         cause_o[CA_EXC_LO +: CODE_W]         = code_i;
         if (srs_rotate) begin
            srs_o[SRS_PREV_LO +: SRS_W] = srs_i[SRS_CUR_LO +: SRS_W];
            srs_o[SRS_CUR_LO +: SRS_W]  = srs_i[SRS_EXC_LO +: SRS_W];
         end
      end
   end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
   import exc_entry_pkg::*;
#(
   parameter int          XLEN           = 32,
   parameter int          INSN_BYTES     = 4,
   parameter int          SRS_W          = 4,
   parameter bit          HAS_DELAY_SLOT = 1'b1,
   parameter logic [31:0] VEC_NORMAL     = 32'h8000_0000,
   parameter logic [31:0] VEC_BOOT       = 32'hBFC0_0200,
   parameter logic [31:0] RESET_VEC      = 32'hBFC0_0000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   input  logic [FAULT_W-1:0] req_fault,
   input  logic [XLEN-1:0]    cur_pc,
   input  logic [XLEN-1:0]    next_pc,
   input  logic [XLEN-1:0]    status_in,
   input  logic [XLEN-1:0]    cause_in,
   input  logic [XLEN-1:0]    srsctl_in,
   output logic               commit_valid,
   output logic [XLEN-1:0]    status_out,
   output logic [XLEN-1:0]    cause_out,
   output logic [XLEN-1:0]    srsctl_out,
   output logic [XLEN-1:0]    epc_out,
   output logic               epc_we,
   output logic [XLEN-1:0]    redirect_pc
);
   localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

   generate
      if (XLEN < 32) begin : g_bad_xlen
         $error("exc_entry_unit: XLEN must be at least 32");
      end
      if (SRS_W < 1 || SRS_PREV_LO + SRS_W > SRS_EXC_LO || SRS_CUR_LO + SRS_W > SRS_PREV_LO) begin : g_bad_srs
         $error("exc_entry_unit: SRS_W does not fit the field layout");
      end
      if (INSN_BYTES < 1) begin : g_bad_insn
         $error("exc_entry_unit: INSN_BYTES must be positive");
      end
   endgenerate

   logic [CODE_W-1:0] code;
   logic              low_off, is_reset;
   logic [XLEN-1:0]   status_n, cause_n, srs_n, epc_n, target_n;
   logic              epc_we_n;
   logic              accept;

   exc_code_map u_map (
      .fault_i    (req_fault),
      .code_o     (code),
      .low_off_o  (low_off),
      .is_reset_o (is_reset)
   );

   exc_state_calc #(
      .XLEN           (XLEN),
      .INSN_BYTES     (INSN_BYTES),
      .SRS_W          (SRS_W),
      .HAS_DELAY_SLOT (HAS_DELAY_SLOT),
      .VEC_NORMAL     (VEC_NORMAL),
      .VEC_BOOT       (VEC_BOOT),
      .RESET_VEC      (RESET_VEC)
   ) u_calc (
      .pc_i       (cur_pc),
      .npc_i      (next_pc),
      .status_i   (status_in),
      .cause_i    (cause_in),
      .srs_i      (srsctl_in),
      .code_i     (code),
      .low_off_i  (low_off),
      .is_reset_i (is_reset),
      .status_o   (status_n),
      .cause_o    (cause_n),
      .srs_o      (srs_n),
      .epc_o      (epc_n),
      .target_o   (target_n),
      .epc_we_o   (epc_we_n)
   );

   assign accept = req_valid && !commit_valid;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         commit_valid <= 1'b0;
         status_out   <= '0;
         cause_out    <= '0;
         srsctl_out   <= '0;
         epc_out      <= '0;
         epc_we       <= 1'b0;
         redirect_pc  <= '0;
      end else begin
         commit_valid <= accept;
         if (accept) begin
            status_out  <= status_n;
            cause_out   <= cause_n;
            srsctl_out  <= srs_n;
            epc_out     <= epc_n;
            epc_we      <= epc_we_n;
            redirect_pc <= target_n;
         end
      end
   end

   // R1
   commit_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !commit_valid) |=> commit_valid);
   // R1
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      commit_valid |=> !commit_valid);
   // R2
   exl_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_valid && epc_we) |-> status_out[ST_EXL]);
   // R4
   epc_backup_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_valid && epc_we) |->
         epc_out == ($past(cur_pc) - (cause_out[CA_BD] ? STEP : '0)));
   // R5
   ce_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_valid && epc_we) |-> cause_out[CA_CE_LO +: 2] == 2'b00);
   // R8
   reset_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (commit_valid && !epc_we) |-> (redirect_pc == XLEN'(RESET_VEC) && status_out[ST_CU1]));
endmodule

// File: tb/exc_entry_unit_test.sv
module exc_entry_unit_test;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic [4:0]  req_fault = '0;
   logic [31:0] cur_pc = '0, next_pc = '0, status_in = '0, cause_in = '0, srsctl_in = '0;
   logic        commit_valid, epc_we;
   logic [31:0] status_out, cause_out, srsctl_out, epc_out, redirect_pc;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   exc_entry_unit uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_fault(req_fault),
      .cur_pc(cur_pc), .next_pc(next_pc), .status_in(status_in), .cause_in(cause_in),
      .srsctl_in(srsctl_in), .commit_valid(commit_valid), .status_out(status_out),
      .cause_out(cause_out), .srsctl_out(srsctl_out), .epc_out(epc_out),
      .epc_we(epc_we), .redirect_pc(redirect_pc)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // drive a request for one cycle; return at the negedge where the commit is visible
   task automatic fire(input logic [4:0] f, input logic [31:0] pc, input logic [31:0] npc,
                       input logic [31:0] st, input logic [31:0] ca, input logic [31:0] srs);
      @(negedge clk);
      req_valid = 1'b1; req_fault = f; cur_pc = pc; next_pc = npc;
      status_in = st; cause_in = ca; srsctl_in = srs;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic t_reset_state;
      chk("R9", "commit_valid after reset", {31'd0, commit_valid}, 32'd0);
   endtask

   task automatic t_plain;
      fire(5'd9, 32'h0000_1000, 32'h0000_1004, 32'h0000_0000, 32'h3000_0300, 32'h0000_3005);
      chk("R1", "commit_valid", {31'd0, commit_valid}, 32'd1);
      chk("R2", "status", status_out, 32'h0000_0002);
      chk("R2", "epc_we", {31'd0, epc_we}, 32'd1);
      chk("R3", "srsctl rotate", srsctl_out, 32'h0000_3143);
      chk("R4", "epc no slot", epc_out, 32'h0000_1000);
      chk("R5", "cause overflow", cause_out, 32'h0000_0330);
      chk("R7", "vector", redirect_pc, 32'h8000_0180);
   endtask

   task automatic t_slot;
      fire(5'd5, 32'h0000_2004, 32'h0000_3000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000);
      chk("R4", "epc slot", epc_out, 32'h0000_2000);
      chk("R5", "cause slot syscall", cause_out, 32'h8000_0020);
   endtask

   task automatic t_exl_set;
      fire(5'd6, 32'h0000_4000, 32'h0000_4004, 32'h0000_0003, 32'h0000_0000, 32'h0000_3005);
      chk("R2", "status exl kept", status_out, 32'h0000_0003);
      chk("R3", "srsctl held exl", srsctl_out, 32'h0000_3005);
   endtask

   task automatic t_bev;
      fire(5'd7, 32'h0000_5000, 32'h0000_5004, 32'h0040_0000, 32'h0000_0000, 32'h0000_3005);
      chk("R2", "status bev", status_out, 32'h0040_0002);
      chk("R3", "srsctl held bev", srsctl_out, 32'h0000_3005);
      chk("R7", "boot vector", redirect_pc, 32'hBFC0_0380);
   endtask

   task automatic t_codes;
      logic [4:0] fl [11] = '{5'd0, 5'd1, 5'd2, 5'd5, 5'd6, 5'd7, 5'd8, 5'd9, 5'd10, 5'd11, 5'd12};
      logic [4:0] cd [11] = '{5'd0, 5'd1, 5'd0, 5'd8, 5'd9, 5'd10, 5'd11, 5'd12, 5'd13, 5'd24, 5'd0};
      for (int i = 0; i < 11; i++) begin
         fire(fl[i], 32'h0000_6000, 32'h0000_6004, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000);
         chk("R6", $sformatf("code for fault %0d", fl[i]), {27'd0, cause_out[6:2]}, {27'd0, cd[i]});
         chk("R7", $sformatf("vector for fault %0d", fl[i]), redirect_pc,
             (fl[i] == 5'd0) ? 32'h8000_0000 : 32'h8000_0180);
      end
   endtask

   task automatic t_low_vec;
      fire(5'd16, 32'h0000_7000, 32'h0000_7004, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000);
      chk("R7", "nmi vector", redirect_pc, 32'h8000_0000);
      fire(5'd15, 32'h0000_7000, 32'h0000_7004, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000);
      chk("R7", "soft reset vector", redirect_pc, 32'h8000_0000);
      chk("R2", "soft reset epc_we", {31'd0, epc_we}, 32'd1);
      fire(5'd0, 32'h0000_7000, 32'h0000_7004, 32'h0040_0000, 32'h0000_0000, 32'h0000_0000);
      chk("R7", "interrupt boot vector", redirect_pc, 32'hBFC0_0200);
   endtask

   task automatic t_reset_fault;
      fire(5'd14, 32'h0000_8008, 32'h0000_9000, 32'h0040_0000, 32'h1234_0008, 32'h0000_3005);
      chk("R8", "reset vector", redirect_pc, 32'hBFC0_0000);
      chk("R8", "reset epc_we", {31'd0, epc_we}, 32'd0);
      chk("R8", "reset status", status_out, 32'h2040_0000);
      chk("R8", "reset cause", cause_out, 32'h1234_0008);
      chk("R8", "reset srsctl", srsctl_out, 32'h0000_3005);
   endtask

   task automatic t_busy;
      fire(5'd10, 32'h0000_A000, 32'h0000_A004, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000);
      chk("R1", "first commit", {31'd0, commit_valid}, 32'd1);
      req_valid = 1'b1; req_fault = 5'd5; cur_pc = 32'h0000_B000; next_pc = 32'h0000_C000;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R1", "busy request ignored", {31'd0, commit_valid}, 32'd0);
      chk("R1", "epc unchanged", epc_out, 32'h0000_A000);
      chk("R1", "cause unchanged", cause_out, 32'h0000_0034);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_plain();
      t_slot();
      t_exl_set();
      t_bev();
      t_codes();
      t_low_vec();
      t_reset_fault();
      t_busy();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule